// File: doc/BRIEF.md
# Dual-Mode Hamming ECC Generator

This block accumulates Hamming parity over a stream of bytes so that a stored block can later be checked and repaired. Each byte arrives with a valid strobe. From the bits of the block it forms a 3-byte code that locates any single flipped bit and flags any pair of flipped bits. It does so by keeping paired even/odd parities over the in-block byte offset (line parity) and over the bit index inside the byte (column parity).

A mode input picks the block shape. With `mode_i` low, two codes are produced: one over the first 256 accepted bytes and one over the next 256. With `mode_i` high, a single code covers the first 512 bytes. Once the last code of the selected shape is captured, the block stops accepting data and its results stay fixed. A one-cycle `rearm_i` strobe clears everything and starts a new count. `mode_i` is expected to stay steady between two rearm strobes.

Top module: `ecc_dual_gen`

## Requirements
- R1: With `mode_i`=0, `code1_o` receives the code of accepted bytes 0..255 on the clock edge that accepts byte 255. `code1_vld_o` rises on that same edge and stays low before it.
- R2: With `mode_i`=0, `code2_o` receives the code of accepted bytes 256..511 on the edge that accepts byte 511, and `code2_vld_o` rises on that edge. `code2_vld_o` is never high while `code1_vld_o` is low.
- R3: With `mode_i`=1, `code1_o` receives the code of bytes 0..511 on the edge that accepts byte 511. `code1_vld_o` stays low until then. `code2_o` stays 0 and `code2_vld_o` stays low.
- R4: Code layout, with `a` the byte offset inside its block and `i` the bit index 0..7. For k=0..2, bit 2k is the XOR of all data bits with bit k of `i` set, and bit 2k+1 is the XOR of those with it clear. For line bit j, bit 6+2j is the XOR of all data bits of bytes with bit j of `a` set, and bit 7+2j is the XOR of those with it clear. j runs 0..7 in mode 0 (bits 23:22 are then 1) and 0..8 in mode 1.
- R5: If exactly one data bit of a block changes, the XOR of the old and new code has exactly one bit set in every pair (2m, 2m+1). The even-numbered bits of those pairs spell out the bit index (pairs 0..2) and the in-block offset (the line pairs). The code of the other block does not change.
- R6: If two distinct data bits of one block change, the code XOR is non-zero and no pair has exactly one bit set.
- R7: After the last code of the selected mode is captured, further byte strobes change neither code nor either valid flag.
- R8: A `rearm_i` strobe clears both codes to 0 and both valid flags on the next edge, and restarts the byte count at 0.
- R9: A byte strobed in the same cycle as `rearm_i` is discarded. This holds even when it would have been the last byte of a block.
- R10: While `rst_n` is low, both codes are 0 and both valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rearm_i | input | 1 | One-cycle strobe: clear codes and restart counting |
| mode_i | input | 1 | 0: two 256-byte codes, 1: one 512-byte code |
| byte_vld_i | input | 1 | Qualifies `byte_i` this cycle |
| byte_i | input | 8 | Data byte |
| code1_o | output | 2*BLK_AW+8 (24) | First result code |
| code2_o | output | 2*BLK_AW+8 (24) | Second result code (mode 0 only) |
| code1_vld_o | output | 1 | `code1_o` holds a captured code |
| code2_vld_o | output | 1 | `code2_o` holds a captured code |

## Verification
The re-arm strobe and a byte strobe can land in the same cycle. That includes the cycle carrying the byte that would close a block, where the capture and the clear compete for the same result register. The bench drives both at once, once in the middle of a stream and once on byte 255. It then judges that no code was captured and that the following 256 bytes, counted from offset 0, yield exactly the computed code. A discarded byte that was counted would shift every offset and change the line parity.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;

  localparam int BYTE_W    = 8;
  localparam int COL_PAIRS = 3;
  localparam int COL_W     = 2 * COL_PAIRS;

  // column parity of one byte: [2k] over bits whose index has bit k set,
  // [2k+1] over bits whose index has bit k clear
  function automatic logic [COL_W-1:0] col_parity(input logic [BYTE_W-1:0] d);
    logic [COL_W-1:0] c;
    c = '0;
    for (int k = 0; k < COL_PAIRS; k++) begin
      for (int i = 0; i < BYTE_W; i++) begin
        if (((i >> k) & 1) == 1) c[2*k]   = c[2*k]   ^ d[i];
        else                     c[2*k+1] = c[2*k+1] ^ d[i];
      end
    end
    return c;
  endfunction

  // one line-parity pair: [0] when the offset bit is set, [1] when clear
  function automatic logic [1:0] line_pair(input logic offs_bit, input logic byte_par);
    return {byte_par & ~offs_bit, byte_par & offs_bit};
  endfunction

endpackage

// File: rtl/ecc_blk_counter.sv
module ecc_blk_counter #(
  parameter int BLK_AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rearm_i,
  input  logic            byte_vld_i,
  output logic            take_o,
  output logic [BLK_AW:0] offs_o,
  output logic            end_lo_o,
  output logic            end_hi_o
);

  logic [BLK_AW:0] cnt_q;
  logic            done_q;

  // rearm wins over a coincident byte; nothing is taken once done
  assign take_o   = byte_vld_i & ~rearm_i & ~done_q;
  assign offs_o   = cnt_q;
  assign end_lo_o = take_o & ~cnt_q[BLK_AW] & (&cnt_q[BLK_AW-1:0]);
  assign end_hi_o = take_o & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (rearm_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (end_hi_o) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
  import ecc_gen_pkg::*;
#(
  parameter int BLK_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rearm_i,
  input  logic                      take_i,
  input  logic                      restart_i,
  input  logic                      mode_i,
  input  logic [BLK_AW:0]           offs_i,
  input  logic [BYTE_W-1:0]         byte_i,
  output logic [2*BLK_AW+COL_W+1:0] code_nxt_o
);

  localparam int LINE_W = 2 * (BLK_AW + 1);
  localparam int CODE_W = LINE_W + COL_W;

  logic              byte_par;
  logic [LINE_W-1:0] line_c;
  logic [CODE_W-1:0] contrib;
  logic [CODE_W-1:0] sum;
  logic [CODE_W-1:0] acc_q;

  assign byte_par = ^byte_i;

  for (genvar j = 0; j <= BLK_AW; j++) begin : g_line
    if (j < BLK_AW) begin : g_low
      assign line_c[2*j+1:2*j] = line_pair(offs_i[j], byte_par);
    end else begin : g_top
      // the top offset bit only counts for the long block
      assign line_c[2*j+1:2*j] = mode_i ? line_pair(offs_i[j], byte_par) : 2'b00;
    end
  end

  assign contrib = {line_c, col_parity(byte_i)};
  assign sum     = acc_q ^ contrib;

  // short-block codes carry ones in the unused top pair
  assign code_nxt_o = mode_i ? sum : {2'b11, sum[CODE_W-3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (rearm_i) begin
      acc_q <= '0;
    end else if (take_i) begin
      acc_q <= restart_i ? '0 : sum;
    end
  end

endmodule

// File: rtl/ecc_result_bank.sv
module ecc_result_bank #(
  parameter int CODE_W = 24,
  parameter int SLOTS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rearm_i,
  input  logic [SLOTS-1:0]             wr_i,
  input  logic [CODE_W-1:0]            code_i,
  output logic [SLOTS-1:0][CODE_W-1:0] code_o,
  output logic [SLOTS-1:0]             vld_o
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (rearm_i) begin
        code_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (wr_i[g]) begin
        code_o[g] <= code_i;
        vld_o[g]  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_dual_gen.sv
module ecc_dual_gen
  import ecc_gen_pkg::*;
#(
  parameter int BLK_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rearm_i,
  input  logic                      mode_i,
  input  logic                      byte_vld_i,
  input  logic [BYTE_W-1:0]         byte_i,
  output logic [2*BLK_AW+COL_W+1:0] code1_o,
  output logic [2*BLK_AW+COL_W+1:0] code2_o,
  output logic                      code1_vld_o,
  output logic                      code2_vld_o
);

  localparam int CODE_W = 2 * (BLK_AW + 1) + COL_W;
  localparam int SLOTS  = 2;

  // named internal events
  logic                         take_w;
  logic                         end_lo_w;
  logic                         end_hi_w;
  logic                         restart_w;
  logic [BLK_AW:0]              offs_w;
  logic [CODE_W-1:0]            code_nxt_w;
  logic [SLOTS-1:0]             wr_w;
  logic [SLOTS-1:0][CODE_W-1:0] bank_w;
  logic [SLOTS-1:0]             vld_w;

  ecc_blk_counter #(.BLK_AW(BLK_AW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .rearm_i    (rearm_i),
    .byte_vld_i (byte_vld_i),
    .take_o     (take_w),
    .offs_o     (offs_w),
    .end_lo_o   (end_lo_w),
    .end_hi_o   (end_hi_w)
  );

  assign restart_w = end_lo_w & ~mode_i;

  ecc_parity_acc #(.BLK_AW(BLK_AW)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .rearm_i    (rearm_i),
    .take_i     (take_w),
    .restart_i  (restart_w),
    .mode_i     (mode_i),
    .offs_i     (offs_w),
    .byte_i     (byte_i),
    .code_nxt_o (code_nxt_w)
  );

  assign wr_w[0] = mode_i ? end_hi_w : end_lo_w;
  assign wr_w[1] = ~mode_i & end_hi_w;

  ecc_result_bank #(.CODE_W(CODE_W), .SLOTS(SLOTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rearm_i (rearm_i),
    .wr_i    (wr_w),
    .code_i  (code_nxt_w),
    .code_o  (bank_w),
    .vld_o   (vld_w)
  );

  assign code1_o     = bank_w[0];
  assign code2_o     = bank_w[1];
  assign code1_vld_o = vld_w[0];
  assign code2_vld_o = vld_w[1];

endmodule

// File: rtl/ecc_dual_gen_chk.sv
module ecc_dual_gen_chk #(
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rearm_i,
  input logic              mode_i,
  input logic              end_lo_w,
  input logic [CODE_W-1:0] code1_o,
  input logic [CODE_W-1:0] code2_o,
  input logic              code1_vld_o,
  input logic              code2_vld_o
);

  AST_CODE1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code1_vld_o && !rearm_i) |=> (code1_vld_o && $stable(code1_o))); // R7

  AST_CODE2_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code2_vld_o && !rearm_i) |=> (code2_vld_o && $stable(code2_o))); // R7

  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (!code1_vld_o && !code2_vld_o && code1_o == '0 && code2_o == '0)); // R8

  AST_CODE2_AFTER_CODE1: assert property (@(posedge clk) disable iff (!rst_n)
    code2_vld_o |-> code1_vld_o); // R2

  AST_MODE1_NO_CODE2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !code2_vld_o) |=> !code2_vld_o); // R3

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (end_lo_w && !mode_i) |=> (code1_o[CODE_W-1 -: 2] == 2'b11)); // R4

endmodule

bind ecc_dual_gen ecc_dual_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rearm_i     (rearm_i),
  .mode_i      (mode_i),
  .end_lo_w    (end_lo_w),
  .code1_o     (code1_o),
  .code2_o     (code2_o),
  .code1_vld_o (code1_vld_o),
  .code2_vld_o (code2_vld_o)
);

// File: tb/test_ecc_dual_gen.sv
`timescale 1ns/1ps
module test_ecc_dual_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rearm = 1'b0;
  logic        mode = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  dat = 8'h00;
  logic [23:0] c1, c2;
  logic        v1, v2;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [7:0]  mem [512];
  logic [23:0] g1, g2;

  always #4 clk = ~clk;

  ecc_dual_gen i_ecc_dual_gen (
    .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .mode_i(mode),
    .byte_vld_i(vld), .byte_i(dat),
    .code1_o(c1), .code2_o(c2), .code1_vld_o(v1), .code2_vld_o(v2)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bit-by-bit toggling form of the code layout
  function automatic logic [23:0] ref_code(input int base, input int len, input bit m1);
    logic [23:0] r;
    int na;
    r  = '0;
    na = m1 ? 9 : 8;
    for (int a = 0; a < len; a++)
      for (int i = 0; i < 8; i++)
        if (mem[base+a][i]) begin
          for (int k = 0; k < 3; k++)
            if (((i >> k) & 1) == 1) r[2*k] = ~r[2*k]; else r[2*k+1] = ~r[2*k+1];
          for (int j = 0; j < na; j++)
            if (((a >> j) & 1) == 1) r[6+2*j] = ~r[6+2*j]; else r[7+2*j] = ~r[7+2*j];
        end
    if (!m1) r[23:22] = 2'b11;
    return r;
  endfunction

  // {all pairs single, offset, bit index}
  function automatic logic [12:0] dec(input logic [23:0] d, input int na);
    logic ok;
    logic [8:0] o;
    logic [2:0] b;
    ok = 1'b1; o = '0; b = '0;
    for (int k = 0; k < 3; k++) begin
      if (d[2*k] == d[2*k+1]) ok = 1'b0;
      b[k] = d[2*k];
    end
    for (int j = 0; j < na; j++) begin
      if (d[6+2*j] == d[7+2*j]) ok = 1'b0;
      o[j] = d[6+2*j];
    end
    return {ok, o, b};
  endfunction

  function automatic void fill(input int kind);
    for (int a = 0; a < 512; a++)
      case (kind)
        0: mem[a] = 8'h00;
        1: mem[a] = 8'hff;
        2: mem[a] = 8'(a * 37 + 11) ^ 8'(a >> 3);
        3: mem[a] = (a == 77 || a == 400) ? 8'h10 : 8'h00;
        default: mem[a] = 8'(1 << (a % 8));
      endcase
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk); rearm = 1'b0; vld = 1'b1; dat = b;
  endtask

  task automatic idle();
    @(negedge clk); rearm = 1'b0; vld = 1'b0;
  endtask

  task automatic full_run(input bit m, output logic [23:0] o1, output logic [23:0] o2);
    logic [1:0] vv;
    @(negedge clk); mode = m; rearm = 1'b1; vld = 1'b0;
    @(negedge clk); rearm = 1'b0;
    chk("R8 codes cleared", c1 | c2, 24'h0);
    chk("R8 valids cleared", {22'h0, v2, v1}, 24'h0);
    for (int a = 0; a < 255; a++) send(mem[a]);
    idle();
    chk("R1/R3 no valid before last byte", {23'h0, v1}, 24'h0);
    send(mem[255]); idle();
    if (!m) begin
      chk("R1 first short code", c1, ref_code(0, 256, 1'b0));
      chk("R4 pad bits", {22'h0, c1[23:22]}, 24'h3);
      chk("R1 code1 valid", {22'h0, v2, v1}, 24'h1);
    end else begin
      chk("R3 no early valid", {22'h0, v2, v1}, 24'h0);
    end
    for (int a = 256; a < 512; a++) send(mem[a]);
    idle();
    if (!m) begin
      chk("R2 second short code", c2, ref_code(256, 256, 1'b0));
      chk("R2 both valid", {22'h0, v2, v1}, 24'h3);
    end else begin
      chk("R3 long code", c1, ref_code(0, 512, 1'b1));
      chk("R3 code2 unused", c2, 24'h0);
      chk("R3 valids", {22'h0, v2, v1}, 24'h1);
    end
    o1 = c1; o2 = c2; vv = {v2, v1};
    for (int a = 0; a < 30; a++) send(~mem[a] ^ 8'h5a);
    idle();
    chk("R7 code1 frozen", c1, o1);
    chk("R7 code2 frozen", c2, o2);
    chk("R7 valids frozen", {22'h0, v2, v1}, {22'h0, vv});
  endtask

  task automatic sec_probe(input bit m, input int pos, input int bn,
                           input logic [23:0] b1, input logic [23:0] b2);
    logic [23:0] e1, e2;
    mem[pos][bn] = ~mem[pos][bn];
    full_run(m, e1, e2);
    mem[pos][bn] = ~mem[pos][bn];
    if (m)
      chk("R5 long locate", {11'h0, dec(e1 ^ b1, 9)}, {11'h0, 1'b1, 9'(pos), 3'(bn)});
    else if (pos < 256) begin
      chk("R5 short locate blk1", {11'h0, dec(e1 ^ b1, 8)}, {11'h0, 1'b1, 9'(pos), 3'(bn)});
      chk("R5 other block unchanged", e2, b2);
    end else begin
      chk("R5 short locate blk2", {11'h0, dec(e2 ^ b2, 8)}, {11'h0, 1'b1, 9'(pos - 256), 3'(bn)});
      chk("R5 other block unchanged", e1, b1);
    end
  endtask

  task automatic ded_probe(input bit m, input int p1, input int q1, input int p2, input int q2,
                           input logic [23:0] b1);
    logic [23:0] e1, e2, d;
    mem[p1][q1] = ~mem[p1][q1];
    mem[p2][q2] = ~mem[p2][q2];
    full_run(m, e1, e2);
    mem[p1][q1] = ~mem[p1][q1];
    mem[p2][q2] = ~mem[p2][q2];
    d = e1 ^ b1;
    chk("R6 double flip detected nonzero", {23'h0, d != 24'h0}, 24'h1);
    chk("R6 double flip not single", {23'h0, dec(d, m ? 9 : 8)[12]}, 24'h0);
  endtask

  initial begin
    int pos_l [5] = '{0, 255, 300, 511, 128};
    int bit_l [5] = '{0, 7, 3, 5, 4};
    logic [23:0] b1, b2;
    repeat (3) @(negedge clk);
    chk("R10 codes in reset", c1 | c2, 24'h0);
    chk("R10 valids in reset", {22'h0, v2, v1}, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 codes after reset", c1 | c2, 24'h0);

    for (int kind = 0; kind < 5; kind++)
      for (int m = 0; m < 2; m++) begin
        fill(kind);
        full_run(m[0], g1, g2);
      end

    for (int m = 0; m < 2; m++) begin
      fill(2);
      full_run(m[0], b1, b2);
      for (int p = 0; p < 5; p++) sec_probe(m[0], pos_l[p], bit_l[p], b1, b2);
    end

    fill(2);
    full_run(1'b0, b1, b2);
    ded_probe(1'b0, 10, 2, 200, 6, b1);
    ded_probe(1'b0, 40, 1, 40, 5, b1);
    full_run(1'b1, b1, b2);
    ded_probe(1'b1, 5, 1, 450, 1, b1);

    // R9: rearm together with a byte, mid-stream and on the block-closing byte
    fill(2);
    @(negedge clk); mode = 1'b0; rearm = 1'b1; vld = 1'b0;
    @(negedge clk); rearm = 1'b0;
    for (int a = 0; a < 128; a++) send(8'(a) ^ 8'h3c);
    @(negedge clk); rearm = 1'b1; vld = 1'b1; dat = 8'hff;
    for (int a = 0; a < 255; a++) send(mem[a]);
    @(negedge clk); rearm = 1'b1; vld = 1'b1; dat = mem[255];
    idle();
    chk("R9 closing byte dropped, no valid", {23'h0, v1}, 24'h0);
    chk("R9 closing byte dropped, code clear", c1, 24'h0);
    for (int a = 0; a < 256; a++) send(mem[a]);
    idle();
    chk("R9 recount from offset 0", c1, ref_code(0, 256, 1'b0));
    chk("R9 valid after recount", {23'h0, v1}, 24'h1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule